// File: doc/BRIEF.md
# Signed Array Multiplier (Baugh-Wooley)

This block multiplies two two's complement operands of equal width and returns the full signed product, which is twice as wide. No sign extension is used. The partial-product bits that pair one operand's sign bit with a non-sign bit of the other operand are complemented. A fixed correction row of constant ones compensates for those complemented bits. After this, every summand is non-negative, so the array is built from one kind of cell, the plain full adder.

The partial-product rows are folded one at a time through a chain of carry-save rows. A ripple adder then resolves the last sum and carry vectors into the product. The width is a parameter, and the default is 5 bits. A parameter selects whether the product leaves through a register with one cycle of latency, or leaves combinationally.

Top module: `bw_array_mult`

## Requirements
- R1: For every pair of WIDTH-bit signed operands, `prod_out` equals their 2·WIDTH-bit signed product. With OUT_REG=1 the product appears one clock after the operands are sampled.
- R2: The most negative operand times itself gives +2^(2·WIDTH−2). For 5 bits this is (−16)×(−16)=256.
- R3: When either operand is zero, the product is zero, whatever the other operand is.
- R4: When both operands are nonzero, the top product bit equals the XOR of the two operand sign bits. Examples: (−5)×4=−20, (−4)×3=−12, (−12)×12=−144.
- R5: A synchronous active-high `rst` clears the registered product to zero while it is held, whatever the operands are.
- R6: While both operands are held unchanged, the registered product does not change.
- R7: Products that depend on the complemented cross-sign terms and the correction row are exact: 13×(−5)=−65, (−13)×(−5)=65, (−1)×(−1)=1, and 15×(−16)=−240.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | WIDTH | Multiplicand, two's complement |
| b_in | input | WIDTH | Multiplier, two's complement |
| prod_out | output | 2·WIDTH | Signed product, two's complement |

## Verification
The hardest cases to reach are the operand pairs where the complemented cross-sign terms and the constant correction bits must cancel exactly. These are the most negative value squared, all-ones times all-ones, and the largest positive value times the most negative value. A single wrong correction bit shows up only in some of these combinations. The stimulus therefore sweeps every one of the 2^(2·WIDTH) operand pairs at the default width, and compares each product with an integer product computed in the bench. It also drives the named corner pairs directly and holds the operands steady across several cycles.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

    // Kind of a partial-product term in the Baugh-Wooley matrix
    typedef enum logic {
        TERM_DIRECT   = 1'b0,
        TERM_INVERTED = 1'b1
    } term_kind_e;

    // Full-adder result carried as one datapath item
    typedef struct packed {
        logic carry;
        logic sum;
    } fa_out_t;

    // A term is inverted when exactly one of its two factors is a sign bit
    function automatic term_kind_e term_kind(input int col_a, input int row_b, input int n);
        if ((col_a == n - 1) != (row_b == n - 1))
            return TERM_INVERTED;
        return TERM_DIRECT;
    endfunction

    function automatic logic pp_term(input logic ai, input logic bj, input term_kind_e k);
        if (k == TERM_INVERTED)
            return ~(ai & bj);
        return ai & bj;
    endfunction

    // Constant correction row: ones at column n and at column 2n-1
    function automatic logic corr_bit(input int col, input int n);
        return (col == n) || (col == 2 * n - 1);
    endfunction

endpackage

// File: rtl/bw_fa.sv
module bw_fa
    import bw_mult_pkg::*;
(
    input  logic    x,
    input  logic    y,
    input  logic    z,
    output fa_out_t o
);
    always_comb begin
        o.sum   = x ^ y ^ z;
        o.carry = (x & y) | (y & z) | (x & z);
    end
endmodule

// File: rtl/bw_pp_matrix.sv
module bw_pp_matrix
    import bw_mult_pkg::*;
#(
    parameter int WIDTH = 5,
    localparam int PW   = 2 * WIDTH,
    localparam int ROWS = WIDTH + 1
) (
    input  logic [WIDTH-1:0]         a_vec,
    input  logic [WIDTH-1:0]         b_vec,
    output logic [ROWS-1:0][PW-1:0]  rows
);
    // Rows 0..WIDTH-1: shifted partial products; row WIDTH: correction constants
    for (genvar j = 0; j < WIDTH; j++) begin : g_row
        for (genvar c = 0; c < PW; c++) begin : g_col
            if (c >= j && c < j + WIDTH) begin : g_term
                assign rows[j][c] = pp_term(a_vec[c-j], b_vec[j], term_kind(c - j, j, WIDTH));
            end else begin : g_zero
                assign rows[j][c] = 1'b0;
            end
        end
    end

    for (genvar c = 0; c < PW; c++) begin : g_corr
        assign rows[WIDTH][c] = corr_bit(c, WIDTH);
    end
endmodule

// File: rtl/bw_csa_row.sv
module bw_csa_row
    import bw_mult_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] x_vec,
    input  logic [W-1:0] y_vec,
    input  logic [W-1:0] z_vec,
    output logic [W-1:0] s_vec,
    output logic [W-1:0] c_vec   // already weighted one column up
);
    fa_out_t fa_o [W-1];

    assign c_vec[0]     = 1'b0;
    // Top column: carry would leave the 2N-bit result, so only the sum is kept
    assign s_vec[W-1]   = x_vec[W-1] ^ y_vec[W-1] ^ z_vec[W-1];

    for (genvar k = 0; k < W - 1; k++) begin : g_fa
        bw_fa u_fa (
            .x (x_vec[k]),
            .y (y_vec[k]),
            .z (z_vec[k]),
            .o (fa_o[k])
        );
        assign s_vec[k]   = fa_o[k].sum;
        assign c_vec[k+1] = fa_o[k].carry;
    end
endmodule

// File: rtl/bw_ripple_add.sv
module bw_ripple_add
    import bw_mult_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] x_vec,
    input  logic [W-1:0] y_vec,
    output logic [W-1:0] sum_vec
);
    logic [W-1:0] cy;
    fa_out_t      fa_o [W-1];

    assign cy[0]        = 1'b0;
    assign sum_vec[W-1] = x_vec[W-1] ^ y_vec[W-1] ^ cy[W-1];

    for (genvar k = 0; k < W - 1; k++) begin : g_bit
        bw_fa u_fa (
            .x (x_vec[k]),
            .y (y_vec[k]),
            .z (cy[k]),
            .o (fa_o[k])
        );
        assign sum_vec[k] = fa_o[k].sum;
        assign cy[k+1]    = fa_o[k].carry;
    end
endmodule

// File: rtl/bw_array_mult.sv
module bw_array_mult
    import bw_mult_pkg::*;
#(
    parameter int WIDTH   = 5,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDTH-1:0]   a_in,
    input  logic [WIDTH-1:0]   b_in,
    output logic [2*WIDTH-1:0] prod_out
);
    localparam int PW     = 2 * WIDTH;
    localparam int ROWS   = WIDTH + 1;
    localparam int STAGES = ROWS - 2;
    localparam logic [WIDTH-1:0] OP_MIN = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [PW-1:0]    MIN_SQ = {2'b01, {(PW-2){1'b0}}};

    logic [ROWS-1:0][PW-1:0]   rows;
    logic [STAGES:0][PW-1:0]   acc_s;
    logic [STAGES:0][PW-1:0]   acc_c;
    logic [PW-1:0]             prod_comb;

    bw_pp_matrix #(.WIDTH(WIDTH)) u_matrix (
        .a_vec (a_in),
        .b_vec (b_in),
        .rows  (rows)
    );

    assign acc_s[0] = rows[0];
    assign acc_c[0] = rows[1];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        bw_csa_row #(.W(PW)) u_csa (
            .x_vec (acc_s[k]),
            .y_vec (acc_c[k]),
            .z_vec (rows[k+2]),
            .s_vec (acc_s[k+1]),
            .c_vec (acc_c[k+1])
        );
    end

    bw_ripple_add #(.W(PW)) u_final (
        .x_vec   (acc_s[STAGES]),
        .y_vec   (acc_c[STAGES]),
        .sum_vec (prod_comb)
    );

    // Behavioural product, used only by the checks below
    logic signed [PW-1:0] a_wide, b_wide, ref_prod;
    assign a_wide   = PW'($signed(a_in));
    assign b_wide   = PW'($signed(b_in));
    assign ref_prod = a_wide * b_wide;

    if (OUT_REG) begin : g_reg
        logic [PW-1:0] prod_q;
        logic          live_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q <= '0;
                live_q <= 1'b0;
            end else begin
                prod_q <= prod_comb;
                live_q <= 1'b1;
            end
        end
        assign prod_out = prod_q;

        // R1
        product_match_chk: assert property (@(posedge clk) disable iff (rst)
            live_q |-> prod_out == $past(ref_prod));
        // R2
        min_square_chk: assert property (@(posedge clk) disable iff (rst)
            (a_in == OP_MIN && b_in == OP_MIN) |=> prod_out == MIN_SQ);
        // R3
        zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
            (a_in == '0 || b_in == '0) |=> prod_out == '0);
        // R4
        sign_rule_chk: assert property (@(posedge clk) disable iff (rst)
            (a_in != '0 && b_in != '0) |=> prod_out[PW-1] == ($past(a_in[WIDTH-1]) ^ $past(b_in[WIDTH-1])));
        // R5
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> prod_out == '0);
        // R6
        hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
            (live_q && $stable(a_in) && $stable(b_in)) |=> $stable(prod_out));
    end else begin : g_comb
        assign prod_out = prod_comb;

        // R1
        product_comb_chk: assert property (@(posedge clk) disable iff (rst)
            prod_out == ref_prod);
        // R3
        zero_comb_chk: assert property (@(posedge clk) disable iff (rst)
            (a_in == '0 || b_in == '0) |-> prod_out == '0);
    end
endmodule

// File: tb/bw_array_mult_tb.sv
`timescale 1ns/1ps
module bw_array_mult_tb_top;
    localparam int WIDTH = 5;
    localparam int PW    = 2 * WIDTH;
    localparam int LO    = -(1 << (WIDTH - 1));
    localparam int HI    = (1 << (WIDTH - 1)) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] a_in = '0;
    logic [WIDTH-1:0] b_in = '0;
    logic [PW-1:0]    prod_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    bw_array_mult #(.WIDTH(WIDTH), .OUT_REG(1'b1)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .a_in     (a_in),
        .b_in     (b_in),
        .prod_out (prod_out)
    );

    function automatic int got_val();
        logic signed [PW-1:0] s;
        s = $signed(prod_out);
        return int'(s);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register)
    task automatic mul(input string tag, input int ai, input int bi, input int exp);
        @(negedge clk);
        a_in = ai[WIDTH-1:0];
        b_in = bi[WIDTH-1:0];
        @(negedge clk);
        check(tag, got_val(), exp);
    endtask

    initial begin
        // R5: reset with nonzero operands
        a_in = 5'd13;
        b_in = 5'b11011;
        repeat (3) @(negedge clk);
        check("R5 reset clear", got_val(), 0);
        rst = 1'b0;

        mul("R7 13*-5",   13,  -5,  -65);
        mul("R1 13*5",    13,   5,   65);
        mul("R7 -13*-5", -13,  -5,   65);
        mul("R4 -5*4",    -5,   4,  -20);
        mul("R4 -4*3",    -4,   3,  -12);
        mul("R4 -12*12", -12,  12, -144);
        mul("R7 max*min", HI,  LO,  HI * LO);
        mul("R7 -1*-1",   -1,  -1,    1);
        mul("R2 min*min", LO,  LO,  LO * LO);
        mul("R3 0*min",    0,  LO,    0);
        mul("R3 -7*0",    -7,   0,    0);

        // R1: exhaustive sweep
        for (int ai = LO; ai <= HI; ai++) begin
            for (int bi = LO; bi <= HI; bi++) begin
                mul("R1 sweep", ai, bi, ai * bi);
            end
        end

        // R6: hold operands, product must stay
        mul("R6 hold start", -7, 9, -63);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R6 hold", got_val(), -63);
        end

        // R5: reset in the middle of operation
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R5 mid reset", got_val(), 0);
        @(negedge clk);
        check("R5 reset held", got_val(), 0);
        rst = 1'b0;
        mul("R1 after reset", 11, -3, -33);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule